// File: doc/BRIEF.md
# Gated Dual Interval Timer

This block contains two independent countdown timers, each with a count register, a reload value and a mode register, behind one command port. A command names a timer and an operation: load a value, write the mode, start, stop or acknowledge the interrupt. A read-select input returns the current count of either timer. Each timer steps down by one on every tick of its chosen time base. The time base is either a shared internal prescaled tick or the timer's own external user clock. The external clock can pass through a minimum-width qualifier that rejects short glitches.

A mode bit places the timer under external gate control. The timer then counts only while its active-low gate input is held low. The gate is sampled by level, not by edge. This supports three uses. As an interval timer it runs on the internal tick and raises an interrupt after a set time. As a pulse counter it runs on the external clock with no gate. For pulse-duration measurement the gate is armed, the external clock is selected, and the count runs while the user pulse holds the gate active. When a running timer reaches zero it sets its interrupt request, which is held until acknowledged. In one-shot mode the timer then stops. In reload mode it restarts from the loaded value.

Top module: `gated_timer_pair`

## Requirements
- R1: While `rst_ni` is low, and after it is released, both counts read 0, `run_o` and `irq_o` are 0, and every mode field is cleared (internal time base, no gate, no filter, one-shot). A reset in the middle of a run returns the timer to this state.
- R2: A command is taken on a rising clock edge while `cmd_valid_i` is 1. `cmd_sel_i` picks the timer and `cmd_op_i` picks the operation: 1 = load, 2 = mode, 3 = start, 4 = stop, 5 = acknowledge, 0 = nothing. Load writes `cmd_data_i` to both the count and the reload value. `rd_value_o` shows the count of the timer selected by `rd_sel_i`.
- R3: Start sets the run state only when the count is nonzero; a start with a zero count is ignored. Stop clears the run state and the count then holds. Loading 0 also clears the run state.
- R4: A running timer decrements once per rising edge of its time base. Mode data bit 0 = 0 selects the internal tick, which fires once every `TICK_DIV` clocks. Bit 0 = 1 selects `ext_clk_i` of that timer.
- R5: Mode data bit 15 = 1 enables gate control: the timer counts only while `ext_gate_ni` is low. With bit 15 = 0 the gate input has no effect on counting.
- R6: When a running timer steps from 1 to 0, its `irq_o` bit is set. In one-shot mode (mode bit 1 = 0) the run state drops and the count stays 0.
- R7: In reload mode (mode bit 1 = 1), reaching zero reloads the count from the last loaded value, sets the interrupt and keeps the timer running.
- R8: With mode bit 2 = 1, a level change on the external clock that lasts fewer than `FILT_CYC` clocks is ignored. A level held at least `FILT_CYC` clocks is accepted. With bit 2 = 0, every synchronized edge counts.
- R9: An interrupt stays set until an acknowledge command for that timer, which clears it.
- R10: A command addressed to one timer leaves the other timer's count, run state and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_sel_i | input | 1 | Target timer of the command |
| cmd_op_i | input | 3 | Operation code |
| cmd_data_i | input | 16 | Load value or mode word |
| rd_sel_i | input | 1 | Timer whose count is read |
| rd_value_o | output | 16 | Current count of the selected timer |
| ext_clk_i | input | 2 | External time base, one per timer |
| ext_gate_ni | input | 2 | Active-low external gate, one per timer |
| run_o | output | 2 | Run state per timer |
| irq_o | output | 2 | Interrupt request per timer |

## Verification
The hardest state to reach is a gated count that must hold while external clock edges keep arriving, then resume once the gate goes active, then ignore the gate after the mode bit is cleared, all in one running session. The stimulus keeps the timer running through three stages. It drives bursts of external clock pulses with the gate high, then with the gate low after the synchronizer has settled, then with gate control turned off. It reads the count after each burst. Glitch rejection is reached in a similar way: pulses shorter than the qualifier window are sent, then one long pulse, all on a running filtered timer.

// File: rtl/gtp_pkg.sv
package gtp_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_MODE  = 3'd2,
    OP_START = 3'd3,
    OP_STOP  = 3'd4,
    OP_ACK   = 3'd5
  } op_e;

  localparam int MB_EXT    = 0;
  localparam int MB_RELOAD = 1;
  localparam int MB_FILT   = 2;

  typedef struct packed {
    logic gate_en;
    logic filt;
    logic reload;
    logic ext;
  } mode_t;
endpackage

// File: rtl/gtp_tick_gen.sv
module gtp_tick_gen #(
  parameter int DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + W'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/gtp_clk_qual.sv
module gtp_clk_qual #(
  parameter int FILT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic filt_en_i,
  output logic rise_o
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] FLAST = FW'(FILT_CYC - 1);

  logic s1_q, s2_q, flt_q, lvl_q, lvl;
  logic [FW-1:0] fc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  // level must disagree for FILT_CYC clocks before it is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= 1'b0;
      fc_q  <= '0;
    end else if (s2_q == flt_q) begin
      fc_q <= '0;
    end else if (fc_q == FLAST) begin
      flt_q <= s2_q;
      fc_q  <= '0;
    end else begin
      fc_q <= fc_q + FW'(1);
    end
  end

  assign lvl = filt_en_i ? flt_q : s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl;
  end

  assign rise_o = lvl & ~lvl_q;
endmodule

// File: rtl/gtp_chan.sv
module gtp_chan
  import gtp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int FILT_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_hit_i,
  input  op_e              cmd_op_i,
  input  logic [CNT_W-1:0] cmd_data_i,
  input  logic             int_tick_i,
  input  logic             ext_clk_i,
  input  logic             ext_gate_ni,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             irq_o,
  output logic             gate_on_o,
  output mode_t            mode_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  mode_t            mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic             run_q, run_d, irq_q, irq_d;
  logic             g1_q, g2_q;
  logic             ext_rise, base_tick, gate_ok, step;

  gtp_clk_qual #(.FILT_CYC(FILT_CYC)) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_i     (ext_clk_i),
    .filt_en_i (mode_q.filt),
    .rise_o    (ext_rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g1_q <= 1'b0;
      g2_q <= 1'b0;
    end else begin
      g1_q <= ~ext_gate_ni;
      g2_q <= g1_q;
    end
  end

  assign base_tick = mode_q.ext ? ext_rise : int_tick_i;
  assign gate_ok   = ~mode_q.gate_en | g2_q;
  // a command to this timer takes the cycle; no step that cycle
  assign step      = run_q & base_tick & gate_ok & ~cmd_hit_i;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    rld_d  = rld_q;
    run_d  = run_q;
    irq_d  = irq_q;
    if (cmd_hit_i) begin
      unique case (cmd_op_i)
        OP_LOAD: begin
          cnt_d = cmd_data_i;
          rld_d = cmd_data_i;
          if (cmd_data_i == '0) run_d = 1'b0;
        end
        OP_MODE: begin
          mode_d.gate_en = cmd_data_i[CNT_W-1];
          mode_d.filt    = cmd_data_i[MB_FILT];
          mode_d.reload  = cmd_data_i[MB_RELOAD];
          mode_d.ext     = cmd_data_i[MB_EXT];
        end
        OP_START: run_d = (cnt_q != '0);
        OP_STOP:  run_d = 1'b0;
        OP_ACK:   irq_d = 1'b0;
        default: ;
      endcase
    end else if (step) begin
      if (cnt_q == ONE) begin
        irq_d = 1'b1;
        if (mode_q.reload && rld_q != '0) begin
          cnt_d = rld_q;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      cnt_q  <= '0;
      rld_q  <= '0;
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      run_q  <= run_d;
      irq_q  <= irq_d;
    end
  end

  assign count_o   = cnt_q;
  assign run_o     = run_q;
  assign irq_o     = irq_q;
  assign gate_on_o = g2_q;
  assign mode_o    = mode_q;
endmodule

// File: rtl/gated_timer_pair.sv
module gated_timer_pair
  import gtp_pkg::*;
#(
  parameter int NUM_TMR  = 2,
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 100,
  parameter int FILT_CYC = 16,
  localparam int SEL_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [SEL_W-1:0]   cmd_sel_i,
  input  logic [2:0]         cmd_op_i,
  input  logic [CNT_W-1:0]   cmd_data_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [CNT_W-1:0]   rd_value_o,
  input  logic [NUM_TMR-1:0] ext_clk_i,
  input  logic [NUM_TMR-1:0] ext_gate_ni,
  output logic [NUM_TMR-1:0] run_o,
  output logic [NUM_TMR-1:0] irq_o
);
  logic                          int_tick;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_arr;
  logic [NUM_TMR-1:0]            gate_on, mode_gate, mode_reload;
  mode_t                         mode_arr [NUM_TMR];
  op_e                           op;

  assign op = op_e'(cmd_op_i);

  gtp_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (int_tick)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic hit;
    assign hit = cmd_valid_i && (cmd_sel_i == SEL_W'(i));

    gtp_chan #(.CNT_W(CNT_W), .FILT_CYC(FILT_CYC)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_hit_i   (hit),
      .cmd_op_i    (op),
      .cmd_data_i  (cmd_data_i),
      .int_tick_i  (int_tick),
      .ext_clk_i   (ext_clk_i[i]),
      .ext_gate_ni (ext_gate_ni[i]),
      .count_o     (cnt_arr[i]),
      .run_o       (run_o[i]),
      .irq_o       (irq_o[i]),
      .gate_on_o   (gate_on[i]),
      .mode_o      (mode_arr[i])
    );

    assign mode_gate[i]   = mode_arr[i].gate_en;
    assign mode_reload[i] = mode_arr[i].reload;
  end

  assign rd_value_o = cnt_arr[rd_sel_i];
endmodule

// File: rtl/gtp_chk.sv
module gtp_chk #(
  parameter int NUM_TMR = 2,
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 1
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          cmd_valid_i,
  input logic [SEL_W-1:0]              cmd_sel_i,
  input logic [2:0]                    cmd_op_i,
  input logic [NUM_TMR-1:0]            run_o,
  input logic [NUM_TMR-1:0]            irq_o,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt,
  input logic [NUM_TMR-1:0]            gate_on,
  input logic [NUM_TMR-1:0]            mode_gate,
  input logic [NUM_TMR-1:0]            mode_reload
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    logic hit, ack;
    assign hit = cmd_valid_i && (cmd_sel_i == SEL_W'(i));
    assign ack = hit && (cmd_op_i == 3'd5);

    assert_run_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_o[i] |-> (cnt[i] != '0));

    assert_stop_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_o[i] && !hit) |=> $stable(cnt[i]));

    assert_step_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_o[i] && !hit) |=> (cnt[i] == $past(cnt[i]) ||
                              cnt[i] == $past(cnt[i]) - CNT_W'(1) ||
                              $past(cnt[i]) == CNT_W'(1)));

    assert_gate_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_o[i] && mode_gate[i] && !gate_on[i] && !hit) |=> $stable(cnt[i]));

    assert_irq_at_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[i]) |-> (cnt[i] == '0 || mode_reload[i]));

    assert_irq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[i] && !ack) |=> irq_o[i]);
  end
endmodule

bind gated_timer_pair gtp_chk #(
  .NUM_TMR (NUM_TMR),
  .CNT_W   (CNT_W),
  .SEL_W   (SEL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_sel_i   (cmd_sel_i),
  .cmd_op_i    (cmd_op_i),
  .run_o       (run_o),
  .irq_o       (irq_o),
  .cnt         (cnt_arr),
  .gate_on     (gate_on),
  .mode_gate   (mode_gate),
  .mode_reload (mode_reload)
);

// File: tb/gated_timer_pair_tb.sv
module gated_timer_pair_tb;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic          cmd_sel_i = 1'b0;
  logic [2:0]    cmd_op_i = 3'd0;
  logic [CW-1:0] cmd_data_i = '0;
  logic          rd_sel_i = 1'b0;
  logic [CW-1:0] rd_value_o;
  logic [1:0]    ext_clk_i = 2'b00;
  logic [1:0]    ext_gate_ni = 2'b11;
  logic [1:0]    run_o, irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  gated_timer_pair #(.NUM_TMR(2), .CNT_W(CW), .TICK_DIV(4), .FILT_CYC(6)) u_dut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_sel_i, .cmd_op_i, .cmd_data_i,
    .rd_sel_i, .rd_value_o, .ext_clk_i, .ext_gate_ni, .run_o, .irq_o
  );

  typedef struct packed {
    logic [2:0]    op;
    logic          sel;
    logic [CW-1:0] data;
    logic [CW-1:0] exp_val;
    logic [1:0]    exp_run;
    logic [1:0]    exp_irq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 1'b0, 16'h0001, 16'h0000, 2'b00, 2'b00}, // R2 mode t0 external
    '{3'd2, 1'b1, 16'h0001, 16'h0000, 2'b00, 2'b00}, // R2 mode t1 external
    '{3'd1, 1'b0, 16'h1234, 16'h1234, 2'b00, 2'b00}, // R2 load
    '{3'd1, 1'b1, 16'hBEEF, 16'hBEEF, 2'b00, 2'b00}, // R2 load other
    '{3'd0, 1'b0, 16'h0000, 16'h1234, 2'b00, 2'b00}, // R10 t0 untouched
    '{3'd3, 1'b0, 16'h0000, 16'h1234, 2'b01, 2'b00}, // R3 start
    '{3'd4, 1'b1, 16'h0000, 16'hBEEF, 2'b01, 2'b00}, // R10 stop t1 keeps t0
    '{3'd1, 1'b1, 16'h0000, 16'h0000, 2'b01, 2'b00}, // R2 load zero
    '{3'd3, 1'b1, 16'h0000, 16'h0000, 2'b01, 2'b00}, // R3 start at zero ignored
    '{3'd1, 1'b1, 16'h0007, 16'h0007, 2'b01, 2'b00}, // R2 load
    '{3'd3, 1'b1, 16'h0000, 16'h0007, 2'b11, 2'b00}, // R3 start
    '{3'd1, 1'b0, 16'h0000, 16'h0000, 2'b10, 2'b00}, // R3 load zero stops
    '{3'd4, 1'b1, 16'h0000, 16'h0007, 2'b00, 2'b00}  // R3 stop
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic sel, input logic [CW-1:0] data);
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    cmd_sel_i   = sel;
    cmd_data_i  = data;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    cmd_op_i    = 3'd0;
  endtask

  task automatic rd(input logic sel, output logic [CW-1:0] v);
    rd_sel_i = sel;
    #1;
    v = rd_value_o;
  endtask

  task automatic pulses(input int idx, input int n, input int h, input int l);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      ext_clk_i[idx] = 1'b1;
      repeat (h) @(negedge clk_i);
      ext_clk_i[idx] = 1'b0;
      repeat (l) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [CW-1:0] v;
    // R1 reset state
    settle(3);
    rd(1'b0, v); chk(v == 0, "R1 reset count t0", v, 0);
    rd(1'b1, v); chk(v == 0, "R1 reset count t1", v, 0);
    chk(run_o == 2'b00 && irq_o == 2'b00, "R1 reset run/irq", {run_o, irq_o}, 0);
    rst_ni = 1'b1;
    settle(2);

    for (int n = 0; n < NV; n++) begin
      cmd(VECS[n].op, VECS[n].sel, VECS[n].data);
      settle(1);
      rd(VECS[n].sel, v);
      chk(v == VECS[n].exp_val, $sformatf("R2 R3 R10 vector %0d value", n), v, VECS[n].exp_val);
      chk(run_o == VECS[n].exp_run, $sformatf("R3 R10 vector %0d run", n), run_o, VECS[n].exp_run);
      chk(irq_o == VECS[n].exp_irq, $sformatf("R9 R10 vector %0d irq", n), irq_o, VECS[n].exp_irq);
    end

    // R7 reload
    cmd(3'd2, 1'b0, 16'h0003);
    cmd(3'd1, 1'b0, 16'd3);
    cmd(3'd3, 1'b0, 16'd0);
    pulses(0, 3, 3, 3);
    rd(1'b0, v); chk(v == 3, "R7 reload value", v, 3);
    chk(run_o[0] == 1'b1, "R7 keeps running", run_o[0], 1);
    chk(irq_o[0] == 1'b1, "R7 irq set", irq_o[0], 1);
    // R9 acknowledge
    cmd(3'd5, 1'b0, 16'd0);
    settle(1);
    chk(irq_o[0] == 1'b0, "R9 ack clears", irq_o[0], 0);
    pulses(0, 1, 3, 3);
    rd(1'b0, v); chk(v == 2, "R4 external step", v, 2);
    chk(irq_o[0] == 1'b0, "R9 stays clear", irq_o[0], 0);
    cmd(3'd4, 1'b0, 16'd0);

    // R6 one-shot
    cmd(3'd1, 1'b1, 16'd2);
    cmd(3'd3, 1'b1, 16'd0);
    pulses(1, 2, 3, 3);
    rd(1'b1, v); chk(v == 0, "R6 one-shot zero", v, 0);
    chk(run_o[1] == 1'b0, "R6 run drops", run_o[1], 0);
    chk(irq_o[1] == 1'b1, "R6 irq set", irq_o[1], 1);
    pulses(1, 1, 3, 3);
    rd(1'b1, v); chk(v == 0, "R6 stays zero", v, 0);
    chk(irq_o[1] == 1'b1, "R9 irq held", irq_o[1], 1);
    cmd(3'd5, 1'b1, 16'd0);
    settle(1);
    chk(irq_o[1] == 1'b0, "R9 ack t1", irq_o[1], 0);

    // R5 gate control
    cmd(3'd2, 1'b0, 16'h8001);
    cmd(3'd1, 1'b0, 16'd10);
    cmd(3'd3, 1'b0, 16'd0);
    pulses(0, 3, 3, 3);
    rd(1'b0, v); chk(v == 10, "R5 gate inactive holds", v, 10);
    ext_gate_ni[0] = 1'b0;
    settle(4);
    pulses(0, 3, 3, 3);
    rd(1'b0, v); chk(v == 7, "R5 gate active counts", v, 7);
    ext_gate_ni[0] = 1'b1;
    settle(4);
    cmd(3'd2, 1'b0, 16'h0001);
    pulses(0, 2, 3, 3);
    rd(1'b0, v); chk(v == 5, "R5 gate ignored when disabled", v, 5);
    cmd(3'd4, 1'b0, 16'd0);

    // R8 filter
    cmd(3'd2, 1'b1, 16'h0005);
    cmd(3'd1, 1'b1, 16'd10);
    cmd(3'd3, 1'b1, 16'd0);
    pulses(1, 3, 3, 8);
    rd(1'b1, v); chk(v == 10, "R8 short pulses rejected", v, 10);
    pulses(1, 1, 12, 12);
    rd(1'b1, v); chk(v == 9, "R8 long pulse accepted", v, 9);
    cmd(3'd4, 1'b1, 16'd0);

    // R4 internal tick
    cmd(3'd2, 1'b1, 16'h0000);
    cmd(3'd1, 1'b1, 16'd100);
    cmd(3'd3, 1'b1, 16'd0);
    settle(20);
    rd(1'b1, v); chk(v >= 94 && v <= 96, "R4 internal tick rate", v, 95);
    cmd(3'd4, 1'b1, 16'd0);
    rd(1'b1, v);
    settle(12);
    begin
      logic [CW-1:0] w;
      rd(1'b1, w); chk(w == v, "R3 stop holds count", w, v);
    end

    // R1 reset mid-run
    cmd(3'd2, 1'b0, 16'h0003);
    cmd(3'd1, 1'b0, 16'd50);
    cmd(3'd3, 1'b0, 16'd0);
    settle(2);
    rst_ni = 1'b0;
    settle(2);
    rd(1'b0, v); chk(v == 0, "R1 mid-run reset count", v, 0);
    rd(1'b1, v); chk(v == 0, "R1 mid-run reset count t1", v, 0);
    chk(run_o == 2'b00 && irq_o == 2'b00, "R1 mid-run reset run/irq", {run_o, irq_o}, 0);
    rst_ni = 1'b1;
    settle(2);
    cmd(3'd1, 1'b0, 16'd3);
    cmd(3'd3, 1'b0, 16'd0);
    settle(30);
    rd(1'b0, v); chk(v == 0, "R1 mode cleared, internal one-shot", v, 0);
    chk(run_o[0] == 1'b0 && irq_o[0] == 1'b1, "R1 R6 after reset", {run_o[0], irq_o[0]}, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule